// File: doc/BRIEF.md
# Nine-bit UART transmitter with gap control

This block is an asynchronous serial transmitter for multidrop links. Each character carries a ninth flag bit that tells address bytes apart from data bytes. A host offers one byte and its flag at a time over a valid/ready handshake. A clock-enable input, `baudTick`, sets the pace: each bit on the line lasts a fixed number of these enables.

A frame has five parts in this order:
- a low start bit;
- eight data bits, least significant first;
- the flag bit, in the slot a parity bit would take;
- a high stop bit;
- an optional extra high bit time.

The extra bit time stretches the stop bit, so a receiver that needs a full stop level gets one before the next start edge. Two mode inputs control the stretch. One adds it only after characters whose flag is 1, which are the address bytes that open a message. The other adds it after every character. The mode inputs and the flag are taken when the character is accepted.

The host can tell a transfer is finished in two ways: `txReady` rises again, and `txDone` pulses for one clock.

Top module: `ninebit_uart_tx`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `txLine` is 1, `txReady` is 1 and `txDone` is 0.
- R2: When a character is accepted (`txValid` and `txReady` both high at a rising clock edge), `txLine` goes to 0 from that edge onward. This is the start bit. The eight data bits follow, bit 0 first.
- R3: The bit after data bit 7 carries the value `txNinth` had at acceptance. It comes before the stop bit.
- R4: Every bit, the stop bit included, holds for exactly 16 rising edges at which `baudTick` is 1. While `baudTick` is 0, `txLine` does not change. The stop bit is 1.
- R5: If `gapAddr` is 1 at acceptance and `txNinth` is 1, one extra bit time of 16 ticks follows the stop bit. `txLine` stays 1 during it.
- R6: If `gapAddr` is 1 and `txNinth` is 0, and `gapAll` is 0, no extra time is added. The block becomes ready right at the end of the stop bit.
- R7: If `gapAll` is 1 at acceptance, the extra bit time follows every character, whatever the value of `txNinth`.
- R8: `txReady` is 0 from the clock after acceptance until the stop bit and any extra bit time have ended. While it is 0, `txValid` and `txData` have no effect on the line.
- R9: `txDone` is 1 for exactly one clock. This happens in the cycle in which `txReady` comes back to 1 after a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Bit-rate enable; 16 per bit time |
| txValid | input | 1 | Host offers a character |
| txData | input | 8 | Data byte |
| txNinth | input | 1 | Flag bit; 1 marks an address byte |
| gapAddr | input | 1 | Add one bit time after characters whose flag is 1 |
| gapAll | input | 1 | Add one bit time after every character |
| txReady | output | 1 | Block is idle and will accept a character |
| txLine | output | 1 | Serial output, high when idle |
| txDone | output | 1 | One-clock pulse at the end of a transfer |

## Verification
The assertions assume that `baudTick`, `txValid` and the payload inputs change in step with `clk` and are stable at the rising edge. Under that assumption, the line can only move at an acceptance or on an enabled tick. The bench drives every input on the falling edge. It makes `baudTick` a one-clock pulse every third clock, so that both enabled and disabled cycles occur while a bit is in flight. It changes the mode inputs only while the block is idle. In one scenario it holds `txValid` high with a different byte through a whole frame, to show that new input is ignored while the block is busy.

// File: rtl/ntx_pkg.sv
package ntx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new frame
    logic shift;  // advance to the next bit
  } txStrobe_t;

endpackage

// File: rtl/ntx_datapath.sv
module ntx_datapath
  import ntx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] txData,
  input  logic              txNinth,
  output logic              txLine
);
  localparam int FRAME_BITS = DATA_W + 3;

  logic [FRAME_BITS-1:0] frameReg;

  // frame is sent from bit 0 upward; ones shift in behind, so idle and gap read high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
    end else if (strobe.load) begin
      frameReg <= {1'b1, txNinth, txData, 1'b0};
    end else if (strobe.shift) begin
      frameReg <= {1'b1, frameReg[FRAME_BITS-1:1]};
    end
  end

  assign txLine = frameReg[0];

endmodule

// File: rtl/ntx_control.sv
module ntx_control
  import ntx_pkg::*;
#(
  parameter int FRAME_BITS = 11,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      txValid,
  input  logic      txNinth,
  input  logic      gapAddr,
  input  logic      gapAll,
  output txStrobe_t strobe,
  output logic      txReady,
  output logic      txDone
);
  localparam int TICK_W = $clog2(OVERSAMPLE + 1);
  localparam int IDX_W  = $clog2(FRAME_BITS + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);

  txState_t          state;
  logic [TICK_W-1:0] tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic              gapOn;
  logic              doneReg;
  logic              bitEnd;

  assign lastIdx = gapOn ? IDX_W'(FRAME_BITS) : IDX_W'(FRAME_BITS - 1);
  assign bitEnd  = (state == ST_BUSY) && baudTick && (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      gapOn   <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (txValid) begin
            state   <= ST_BUSY;
            tickCnt <= '0;
            bitIdx  <= '0;
            gapOn   <= gapAll | (gapAddr & txNinth);
          end
        end
        ST_BUSY: begin
          if (baudTick) begin
            if (bitEnd) begin
              tickCnt <= '0;
              if (bitIdx == lastIdx) begin
                state   <= ST_IDLE;
                doneReg <= 1'b1;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = (state == ST_IDLE) && txValid;
    strobe.shift = bitEnd && (bitIdx != lastIdx);
  end

  assign txReady = (state == ST_IDLE);
  assign txDone  = doneReg;

endmodule

// File: rtl/ninebit_uart_tx.sv
module ninebit_uart_tx
  import ntx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  input  logic              txNinth,
  input  logic              gapAddr,
  input  logic              gapAll,
  output logic              txReady,
  output logic              txLine,
  output logic              txDone
);
  localparam int FRAME_BITS = DATA_W + 3;

  txStrobe_t strobe;

  ntx_control #(
    .FRAME_BITS(FRAME_BITS),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .txValid (txValid),
    .txNinth (txNinth),
    .gapAddr (gapAddr),
    .gapAll  (gapAll),
    .strobe  (strobe),
    .txReady (txReady),
    .txDone  (txDone)
  );

  ntx_datapath #(
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .txData (txData),
    .txNinth(txNinth),
    .txLine (txLine)
  );

endmodule

// File: rtl/ntx_checker.sv
module ntx_checker (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic txValid,
  input logic txReady,
  input logic txLine,
  input logic txDone
);

  // R1: an idle block always holds the line at mark
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R2: acceptance starts the start bit on the next cycle
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txLine);

  // R4: without an enabled tick, a busy line holds its level
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!txReady && !baudTick) |=> $stable(txLine));

  // R8: acceptance drops ready
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R8/R9: ready only returns together with the done pulse
  assert_ready_return_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> txDone);

  // R9: done lasts one clock
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  // R9: done only while ready
  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txReady);

endmodule

bind ninebit_uart_tx ntx_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .baudTick(baudTick),
  .txValid (txValid),
  .txReady (txReady),
  .txLine  (txLine),
  .txDone  (txDone)
);

// File: tb/ninebit_uart_tx_tb.sv
`timescale 1ns/1ps
module ninebit_uart_tx_tb;

  localparam int TICK_DIV  = 3;
  localparam int BIT_TICKS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       txValid = 1'b0;
  logic [7:0] txData = '0;
  logic       txNinth = 1'b0;
  logic       gapAddr = 1'b0;
  logic       gapAll = 1'b0;
  logic       txReady;
  logic       txLine;
  logic       txDone;

  int checks = 0;
  int errors = 0;
  int divCnt = 0;

  always #2.5 clk = ~clk;

  // one-clock tick every TICK_DIV clocks, driven away from the active edge
  always @(negedge clk) begin
    divCnt   <= (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    baudTick <= (divCnt == 0);
  end

  ninebit_uart_tx u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .txValid (txValid),
    .txData  (txData),
    .txNinth (txNinth),
    .gapAddr (gapAddr),
    .gapAll  (gapAll),
    .txReady (txReady),
    .txLine  (txLine),
    .txDone  (txDone)
  );

  task automatic check(input logic actual, input logic expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, actual, expected);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!baudTick);
    end
  endtask

  task automatic resetTest();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(txLine, 1'b1, "R1 line in reset");
    check(txReady, 1'b1, "R1 ready in reset");
    check(txDone, 1'b0, "R1 done in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(txLine, 1'b1, "R1 line after reset");
    check(txReady, 1'b1, "R1 ready after reset");
  endtask

  // send one character; holdBusy keeps txValid high with other data during the frame
  task automatic sendFrame(input logic [7:0] d, input logic n, input logic mAddr,
                           input logic mAll, input logic expGap, input logic holdBusy,
                           input string tag);
    logic expBit;
    @(negedge clk);
    gapAddr = mAddr;
    gapAll  = mAll;
    txData  = d;
    txNinth = n;
    txValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(txReady, 1'b0, {tag, " R8 ready low after accept"});
    check(txLine, 1'b0, {tag, " R2 start edge"});
    if (holdBusy) begin
      txData  = ~d;
      txNinth = ~n;
    end else begin
      txValid = 1'b0;
    end
    for (int b = 0; b < 11; b++) begin
      if (b == 0)       expBit = 1'b0;
      else if (b <= 8)  expBit = d[b-1];
      else if (b == 9)  expBit = n;
      else              expBit = 1'b1;
      waitTicks(BIT_TICKS / 2);
      @(negedge clk);
      if (b == 0)      check(txLine, expBit, {tag, " R2 start bit"});
      else if (b <= 8) check(txLine, expBit, {tag, " R2 data bit"});
      else if (b == 9) check(txLine, expBit, {tag, " R3 ninth bit"});
      else             check(txLine, expBit, {tag, " R4 stop bit"});
      if (b == 5) check(txReady, 1'b0, {tag, " R8 ready low mid frame"});
      waitTicks(BIT_TICKS / 2);
    end
    @(negedge clk);
    if (expGap) begin
      check(txReady, 1'b0, {tag, " R5 R7 ready low in gap"});
      check(txLine, 1'b1, {tag, " R5 R7 line high in gap"});
      waitTicks(BIT_TICKS / 2);
      @(negedge clk);
      check(txLine, 1'b1, {tag, " R5 R7 line high mid gap"});
      waitTicks(BIT_TICKS / 2);
      @(negedge clk);
    end
    check(txReady, 1'b1, {tag, " R4 R6 ready at end"});
    check(txDone, 1'b1, {tag, " R9 done at end"});
    txValid = 1'b0;
    @(negedge clk);
    check(txDone, 1'b0, {tag, " R9 done one clock"});
    check(txLine, 1'b1, {tag, " R1 idle line high"});
    check(txReady, 1'b1, {tag, " R8 stays idle with valid low"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    resetTest();
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "plain data");
    sendFrame(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "address no mode R3");
    sendFrame(8'h5A, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "address stretched R5");
    sendFrame(8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "data with addr mode R6");
    sendFrame(8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "data forced gap R7");
    sendFrame(8'h81, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "address forced gap R7");
    sendFrame(8'h6E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "busy input ignored R8");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule